// File: doc/BRIEF.md
# Indirect PHY Register Access Sequencer

This block gives a simple command port access to 16-bit registers inside a PHY that cannot be addressed directly. The only path to those registers is a 32-bit control word driven by the block and a 32-bit status word read back from the PHY side. Every transfer across that path uses a four-phase handshake on one shared acknowledge flag.

A client presents a read or a write with a 16-bit register address and, for writes, 16-bit data. The block then runs the handshakes in order: address capture, data capture, the write or read strobe, and the release of each one. At every edge of the acknowledge flag it polls a bounded number of times. When the command finishes, it returns a one-cycle done pulse, an error flag and the read data. If the acknowledge never reaches the expected level, the command aborts, the control word is cleared and the error flag is raised.

Top module: `phy_reg_access`

## Requirements
- R1: While reset is held and after it is released, `cmd_ready_o` is 1, `ctrl_o` is 0 and `done_o` is 0.
- R2: A command is taken on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both 1. `cmd_ready_o` then stays 0 until the done pulse, and any `cmd_valid_i` seen while busy is ignored.
- R3: Layout of the control word: bits [15:0] carry the address or data, bit 16 is capture-address, bit 17 is capture-data, bit 18 is the write strobe, bit 19 is the read strobe, and bits [31:20] are 0. At most one of bits 16 to 19 is set at any time. In the status word, bit 16 is the acknowledge flag and bits [15:0] are the read data.
- R4: The address phase drives the address alone, then the address with capture-address and waits for ack=1, then the address alone and waits for ack=0.
- R5: A write runs the address phase and then the same three steps with the data and capture-data. It then drives the write strobe alone and waits for ack=1, drives the data alone and waits for ack=0, and finally drives an all-zero control word. The target PHY register then holds the data.
- R6: A read runs the address phase, then drives the read strobe alone and waits for ack=1. It keeps status bits [15:0] from that cycle as the read data, then drives zero and waits for ack=0.
- R7: Each wait samples the acknowledge flag once every `POLL_CYCLES` cycles, for at most `RETRIES` samples. An acknowledge that arrives within that window lets the sequence continue without error.
- R8: If a wait ends without the expected level, the command ends with `err_o`=1 and `ctrl_o`=0 in the done cycle.
- R9: `done_o` is a one-cycle pulse. In that cycle `err_o` and `rdata_o` are valid, with `rdata_o`=0 after a write. `cmd_ready_o` returns to 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Idle, command can be taken |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | 16 | PHY register address |
| cmd_wdata_i | input | 16 | Write data |
| done_o | output | 1 | Command finished (one cycle) |
| err_o | output | 1 | Acknowledge timeout, valid with done |
| rdata_o | output | 16 | Read data, valid with done |
| ctrl_o | output | 32 | Control word toward the PHY |
| stat_i | input | 32 | Status word from the PHY |

## Verification
On every cycle the checker covers several structural rules: the strobe bits are mutually exclusive, the control word is zero whenever done pulses, done lasts exactly one cycle, and the ready signal drops after a command is taken and stays low while done pulses. The order of the control words within a read or a write, the latching of read data at the acknowledge, and the edges of the polling window can only be shown by the bench scenarios. These run the sequencer against a PHY model with configurable latency or a stuck acknowledge. The bench logs every change of the control word and compares that log with the expected sequence.

// File: rtl/phy_acc_pkg.sv
package phy_acc_pkg;
  localparam int unsigned PAY_W   = 16;
  localparam int unsigned CTRL_W  = 32;
  localparam int unsigned CAP_ADR = 16;
  localparam int unsigned CAP_DAT = 17;
  localparam int unsigned WR_STB  = 18;
  localparam int unsigned RD_STB  = 19;
  localparam int unsigned ACK_BIT = 16;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR_SET, ST_ADDR_CAP, ST_ADDR_REL,
    ST_DATA_SET, ST_DATA_CAP, ST_DATA_REL,
    ST_WR_STB, ST_WR_REL, ST_RD_STB, ST_RD_REL, ST_DONE
  } acc_state_e;
endpackage

// File: rtl/phy_ack_poller.sv
module phy_ack_poller #(
  parameter int unsigned POLL_CYCLES = 100,
  parameter int unsigned RETRIES     = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic active_i,
  input  logic expect_i,
  input  logic ack_i,
  output logic hit_o,
  output logic miss_o
);
  localparam int unsigned TW = $clog2(POLL_CYCLES + 1);
  localparam int unsigned RW = $clog2(RETRIES + 1);

  logic [TW-1:0] tick_q;
  logic [RW-1:0] try_q;
  logic          sample;

  assign sample = active_i && (tick_q == TW'(POLL_CYCLES - 1));
  assign hit_o  = sample && (ack_i == expect_i);
  assign miss_o = sample && (ack_i != expect_i) && (try_q == RW'(RETRIES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      try_q  <= '0;
    end else if (clear_i) begin
      tick_q <= '0;
      try_q  <= '0;
    end else if (active_i) begin
      if (sample) begin
        tick_q <= '0;
        try_q  <= try_q + 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/phy_acc_seq.sv
module phy_acc_seq
  import phy_acc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_write_i,
  input  logic [PAY_W-1:0]  cmd_addr_i,
  input  logic [PAY_W-1:0]  cmd_wdata_i,
  input  logic [PAY_W-1:0]  stat_data_i,
  input  logic              hit_i,
  input  logic              miss_i,
  output logic              cmd_ready_o,
  output logic              done_o,
  output logic              err_o,
  output logic [PAY_W-1:0]  rdata_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              step_o,
  output logic              wait_o,
  output logic              expect_o
);
  acc_state_e        state_q, state_d;
  logic              we_q;
  logic [PAY_W-1:0]  addr_q, data_q, rdata_q;
  logic              err_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              accept;

  // control word driven in a given state
  function automatic logic [CTRL_W-1:0] word_for(acc_state_e s, logic [PAY_W-1:0] a,
                                                 logic [PAY_W-1:0] d);
    logic [CTRL_W-1:0] w;
    w = '0;
    unique case (s)
      ST_ADDR_SET, ST_ADDR_REL:            w[PAY_W-1:0] = a;
      ST_ADDR_CAP: begin w[PAY_W-1:0] = a; w[CAP_ADR] = 1'b1; end
      ST_DATA_SET, ST_DATA_REL, ST_WR_REL: w[PAY_W-1:0] = d;
      ST_DATA_CAP: begin w[PAY_W-1:0] = d; w[CAP_DAT] = 1'b1; end
      ST_WR_STB:                           w[WR_STB] = 1'b1;
      ST_RD_STB:                           w[RD_STB] = 1'b1;
      default:                             w = '0;
    endcase
    return w;
  endfunction

  assign accept = (state_q == ST_IDLE) && cmd_valid_i;

  always_comb begin
    state_d = state_q;
    if (miss_i) state_d = ST_DONE;
    else begin
      unique case (state_q)
        ST_IDLE:     if (cmd_valid_i) state_d = ST_ADDR_SET;
        ST_ADDR_SET: state_d = ST_ADDR_CAP;
        ST_ADDR_CAP: if (hit_i) state_d = ST_ADDR_REL;
        ST_ADDR_REL: if (hit_i) state_d = we_q ? ST_DATA_SET : ST_RD_STB;
        ST_DATA_SET: state_d = ST_DATA_CAP;
        ST_DATA_CAP: if (hit_i) state_d = ST_DATA_REL;
        ST_DATA_REL: if (hit_i) state_d = ST_WR_STB;
        ST_WR_STB:   if (hit_i) state_d = ST_WR_REL;
        ST_WR_REL:   if (hit_i) state_d = ST_DONE;
        ST_RD_STB:   if (hit_i) state_d = ST_RD_REL;
        ST_RD_REL:   if (hit_i) state_d = ST_DONE;
        ST_DONE:     state_d = ST_IDLE;
        default:     state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      ctrl_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        we_q    <= cmd_write_i;
        addr_q  <= cmd_addr_i;
        data_q  <= cmd_wdata_i;
        rdata_q <= '0;
        err_q   <= 1'b0;
        ctrl_q  <= word_for(state_d, cmd_addr_i, cmd_wdata_i);
      end else begin
        ctrl_q <= word_for(state_d, addr_q, data_q);
      end
      if (miss_i) err_q <= 1'b1;
      if (state_q == ST_RD_STB && hit_i) rdata_q <= stat_data_i;
    end
  end

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign err_o       = err_q;
  assign rdata_o     = rdata_q;
  assign ctrl_o      = ctrl_q;
  assign step_o      = (state_d != state_q);
  assign wait_o      = state_q inside {ST_ADDR_CAP, ST_ADDR_REL, ST_DATA_CAP, ST_DATA_REL,
                                       ST_WR_STB, ST_WR_REL, ST_RD_STB, ST_RD_REL};
  assign expect_o    = state_q inside {ST_ADDR_CAP, ST_DATA_CAP, ST_WR_STB, ST_RD_STB};
endmodule

// File: rtl/phy_reg_access.sv
module phy_reg_access
  import phy_acc_pkg::*;
#(
  parameter int unsigned POLL_CYCLES = 100,
  parameter int unsigned RETRIES     = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  output logic        cmd_ready_o,
  input  logic        cmd_write_i,
  input  logic [15:0] cmd_addr_i,
  input  logic [15:0] cmd_wdata_i,
  output logic        done_o,
  output logic        err_o,
  output logic [15:0] rdata_o,
  output logic [31:0] ctrl_o,
  input  logic [31:0] stat_i
);
  logic step, wait_st, expect_lvl, hit, miss;

  phy_acc_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_write_i (cmd_write_i),
    .cmd_addr_i  (cmd_addr_i),
    .cmd_wdata_i (cmd_wdata_i),
    .stat_data_i (stat_i[PAY_W-1:0]),
    .hit_i       (hit),
    .miss_i      (miss),
    .cmd_ready_o (cmd_ready_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .rdata_o     (rdata_o),
    .ctrl_o      (ctrl_o),
    .step_o      (step),
    .wait_o      (wait_st),
    .expect_o    (expect_lvl)
  );

  phy_ack_poller #(
    .POLL_CYCLES (POLL_CYCLES),
    .RETRIES     (RETRIES)
  ) u_poll (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (step),
    .active_i (wait_st),
    .expect_i (expect_lvl),
    .ack_i    (stat_i[ACK_BIT]),
    .hit_o    (hit),
    .miss_o   (miss)
  );
endmodule

// File: rtl/phy_reg_access_chk.sv
module phy_reg_access_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_i,
  input logic        cmd_ready_o,
  input logic        done_o,
  input logic [31:0] ctrl_o
);
  a_r3_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ctrl_o[19:16]) <= 1 && ctrl_o[31:20] == '0);

  a_r8_done_ctrl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ctrl_o == '0);

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r2_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);

  a_r2_not_ready_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cmd_ready_o);
endmodule

bind phy_reg_access phy_reg_access_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .done_o      (done_o),
  .ctrl_o      (ctrl_o)
);

// File: tb/phy_reg_access_bench.sv
`timescale 1ns/1ps
module phy_reg_access_bench;
  localparam int unsigned POLL = 4;
  localparam int unsigned TRIES = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [15:0] cmd_addr = '0, cmd_wdata = '0;
  logic        cmd_ready, done, err;
  logic [15:0] rdata;
  logic [31:0] ctrl, stat;

  int checks = 0, errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  phy_reg_access #(.POLL_CYCLES(POLL), .RETRIES(TRIES)) u_phy_reg_access (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_write_i(cmd_write), .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
    .done_o(done), .err_o(err), .rdata_o(rdata), .ctrl_o(ctrl), .stat_i(stat));

  // behavioural PHY: ack follows request after lat cycles, or is forced
  int          lat = 2;
  int          force_mode = 0;  // 0 normal, 1 stuck low, 2 stuck high
  logic        ack = 1'b0;
  int          lcnt = 0;
  logic [15:0] adr_l = '0, dat_l = '0, rd_l = '0;
  logic [15:0] mem [16];
  logic        req;

  assign req  = |ctrl[19:16];
  assign stat = {15'd0, (force_mode == 2) ? 1'b1 : (force_mode == 1) ? 1'b0 : ack, rd_l};

  initial for (int i = 0; i < 16; i++) mem[i] = 16'hA000 | 16'(i);

  always @(posedge clk) begin
    if (ack != req) begin
      if (lcnt + 1 >= lat) begin
        ack  <= req;
        lcnt <= 0;
        if (req) begin
          if (ctrl[16]) adr_l <= ctrl[15:0];
          if (ctrl[17]) dat_l <= ctrl[15:0];
          if (ctrl[18]) mem[adr_l[3:0]] <= dat_l;
          if (ctrl[19]) rd_l <= mem[adr_l[3:0]];
        end
      end else lcnt <= lcnt + 1;
    end else lcnt <= 0;
  end

  // log of control word changes
  logic [31:0] log_w [32];
  int          log_n = 0;
  logic [31:0] prev_w = '0;
  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (ctrl !== prev_w) begin
      if (log_n < 32) log_w[log_n] = ctrl;
      log_n  = log_n + 1;
      prev_w = ctrl;
    end
  end

  task automatic check(input bit ok, input string req_s, input logic [31:0] act,
                       input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req_s, act, exp_v);
    end
  endtask

  // run one command; returns err, rdata at done
  task automatic run_cmd(input logic we, input logic [15:0] a, input logic [15:0] d,
                         output logic e, output logic [15:0] r);
    int n;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    log_n = 0;
    cmd_valid = 1'b1; cmd_write = we; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R2 ready low while busy", 32'(cmd_ready), 0);
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    check(done == 1'b1, "R9 done reached", 32'(done), 1);
    e = err; r = rdata;
    check(ctrl == 0, "R8 ctrl zero at done", ctrl, 0);
    @(negedge clk);
    check(done == 1'b0 && cmd_ready == 1'b1, "R9 one-cycle done then ready",
          {30'd0, done, cmd_ready}, 32'd1);
  endtask

  task automatic t_reset();
    check(cmd_ready == 1'b1, "R1 ready", 32'(cmd_ready), 1);
    check(ctrl == 0, "R1 ctrl", ctrl, 0);
    check(done == 1'b0, "R1 done", 32'(done), 0);
  endtask

  task automatic t_write(input logic [15:0] a, input logic [15:0] d);
    logic e; logic [15:0] r;
    logic [31:0] exp_s [9];
    exp_s = '{32'(a), 32'(a) | 32'h1_0000, 32'(a), 32'(d), 32'(d) | 32'h2_0000, 32'(d),
              32'h4_0000, 32'(d), 32'h0};
    run_cmd(1'b1, a, d, e, r);
    check(e == 1'b0, "R5 write no error", 32'(e), 0);
    check(r == 16'h0, "R9 rdata zero after write", 32'(r), 0);
    check(log_n == 9, "R5 write step count", 32'(log_n), 9);
    for (int i = 0; i < 9 && i < log_n; i++)
      check(log_w[i] == exp_s[i], (i < 3) ? "R4 address phase word" : "R5 write word",
            log_w[i], exp_s[i]);
    check(mem[a[3:0]] == d, "R5 PHY register updated", 32'(mem[a[3:0]]), 32'(d));
  endtask

  task automatic t_read(input logic [15:0] a, input logic [15:0] exp_d);
    logic e; logic [15:0] r;
    logic [31:0] exp_s [5];
    exp_s = '{32'(a), 32'(a) | 32'h1_0000, 32'(a), 32'h8_0000, 32'h0};
    run_cmd(1'b0, a, 16'h0, e, r);
    check(e == 1'b0, "R6 read no error", 32'(e), 0);
    check(r == exp_d, "R6 read data", 32'(r), 32'(exp_d));
    check(log_n == 5, "R6 read step count", 32'(log_n), 5);
    for (int i = 0; i < 5 && i < log_n; i++)
      check(log_w[i] == exp_s[i], "R6 read word", log_w[i], exp_s[i]);
  endtask

  task automatic t_slow_ack();
    lat = 30;  // inside 10 samples x 4 cycles
    t_write(16'h0007, 16'h5A5A);
    t_read(16'h0007, 16'h5A5A);
    lat = 2;
  endtask

  task automatic t_timeout_late();
    logic e; logic [15:0] r;
    lat = 45;  // beyond the last sample
    run_cmd(1'b1, 16'h0003, 16'h1111, e, r);
    check(e == 1'b1, "R7 late ack times out", 32'(e), 1);
    check(mem[3] == 16'hA003, "R8 no write after timeout", 32'(mem[3]), 32'hA003);
    repeat (60) @(negedge clk);
    lat = 2;
  endtask

  task automatic t_stuck(input int mode);
    logic e; logic [15:0] r;
    force_mode = mode;
    run_cmd(1'b0, 16'h0002, 16'h0, e, r);
    check(e == 1'b1, mode == 1 ? "R8 stuck-low timeout" : "R8 stuck-high timeout", 32'(e), 1);
    force_mode = 0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_busy_ignored();
    logic e; logic [15:0] r;
    fork
      run_cmd(1'b1, 16'h0004, 16'hBEEF, e, r);
      begin
        repeat (6) @(negedge clk);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 16'h0005; cmd_wdata = 16'hDEAD;
        @(negedge clk);
        cmd_valid = 1'b0;
      end
    join
    check(mem[5] == 16'hA005, "R2 command while busy ignored", 32'(mem[5]), 32'hA005);
    check(mem[4] == 16'hBEEF, "R2 first command completes", 32'(mem[4]), 32'hBEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(16'h0009, 16'h1234);
    t_read(16'h0009, 16'h1234);
    t_read(16'h000C, 16'hA00C);
    t_write(16'h00F1, 16'h0F0F);
    t_read(16'h00F1, 16'h0F0F);
    t_slow_ack();
    t_timeout_late();
    t_stuck(1);
    t_stuck(2);
    t_read(16'h0009, 16'h1234);
    t_busy_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule